// File: doc/BRIEF.md
# Asynchronous Serial Port with Noise-Filtered Receiver

A full-duplex asynchronous serial port that sends and receives ten-bit frames: one low start bit, eight data bits least significant first, and one high stop bit. An external enable, `tick_i`, pulses at sixteen times the bit rate and sets the timing for both directions. No baud divider is included.

The receiver filters noise. It takes a majority of seven samples around the centre of the start and stop bits, and a majority of three samples for each data bit. It also re-times its bit phase on every falling edge that lands near an expected bit boundary, so a sender whose rate is off by a few percent is still received correctly. A stop bit decided low raises a framing flag. A byte that completes while the previous byte is still unread raises an overrun flag. For multidrop links, software can put the receiver into standby. In standby it discards whole characters until the line has been idle for one character time, then it resumes reception on its own.

The transmitter has a single holding register in front of its shift register. Software can queue a data byte, a whole idle character (ten ones) or a whole break character (ten zeros). A CPU reaches the block through three byte registers. Address 0 is data: reading it returns the receive buffer, writing it queues a transmit byte. Address 1 is control. Address 2 is status.

Top module: `sci_uart`

## Requirements
- R1: A queued frame starts on the first `tick_i` after the holding register fills. Each frame bit drives `txd_o` for exactly 16 ticks, in the order start (0), data bits 0 to 7, stop (1). `txd_o` is high whenever no frame is active.
- R2: Status bit 0 is 1 while the transmit holding register is empty. A write queued while it is 0 is ignored. A frame that is waiting starts directly after the stop bit of the frame on the line.
- R3: Writing the control register with bit 2 set queues ten zero bits (a break). With bit 1 set and bit 2 clear, the write queues ten one bits (an idle character). When both bits are set, the break is queued. Status bit 5 is 1 while the transmitter is sending.
- R4: A received byte is readable at address 0, and status bit 1 is then set. A read of address 0 clears status bits 1, 2 and 3.
- R5: Each data bit is the majority of three samples near its centre. One wrong sample does not change the byte.
- R6: The start and stop bits are each decided by a majority of seven samples. One wrong sample neither rejects a valid start bit nor causes a framing error.
- R7: A falling edge within 4 ticks of an expected bit boundary re-aligns the bit phase. Frames whose bit period is 15 or 17 ticks are received correctly.
- R8: A stop bit decided as 0 sets status bit 3. The byte is still delivered with status bit 1.
- R9: A byte that completes while status bit 1 is set raises status bit 2. The buffer keeps the earlier byte.
- R10: Writing control bit 0 enters standby, shown on status bit 4. In standby no byte is delivered and no receive flag changes. Standby ends after the line has been sampled high for 160 consecutive ticks, counted from the request, and the next character is then received.
- R11: After reset, `txd_o` is high, status reads 0x01, and the receive buffer reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle enable at 16x the bit rate |
| addr_i | input | 2 | Register select: 0 data, 1 control, 2 status |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (read of data clears receive flags) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register |
| txd_o | output | 1 | Serial transmit line |
| rxd_i | input | 1 | Serial receive line |

## Verification
On the transmit side, a wrong bit count, a miscounted tick counter or a dropped holding-register state shows up on `txd_o`. The error appears within one bit time (64 clocks in the bench), because the line is compared on every clock against a behavioural reference. On the receive side, a faulty phase counter or vote threshold shows up only when the frame completes. It appears as a wrong byte or a spurious framing flag. The glitch cases and the 15- and 17-tick frames are chosen so that a shifted window or a missing re-alignment corrupts a known byte. Standby errors show up as a delivered byte, or a missing one, around the 160-tick idle boundary.

// File: rtl/sci_pkg.sv
package sci_pkg;
  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_CTRL = 2'd1,
    REG_STAT = 2'd2
  } reg_sel_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/sci_tx.sv
module sci_tx #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [DATA_W+1:0] frame_i,
  output logic              tdre_o,
  output logic              busy_o,
  output logic              txd_o
);
  localparam int unsigned FRAME_W = DATA_W + 2;
  localparam int unsigned TCW     = $clog2(OVS);
  localparam int unsigned BCW     = $clog2(FRAME_W);

  logic [FRAME_W-1:0] hold_q, shift_q;
  logic               full_q, busy_q;
  logic [TCW-1:0]     tcnt_q;
  logic [BCW-1:0]     bcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      shift_q <= '1;
      full_q  <= 1'b0;
      busy_q  <= 1'b0;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
    end else begin
      if (load_i && !full_q) begin
        hold_q <= frame_i;
        full_q <= 1'b1;
      end
      if (tick_i) begin
        if (!busy_q) begin
          if (full_q) begin
            shift_q <= hold_q;
            full_q  <= 1'b0;
            busy_q  <= 1'b1;
            tcnt_q  <= '0;
            bcnt_q  <= '0;
          end
        end else if (tcnt_q == TCW'(OVS - 1)) begin
          tcnt_q <= '0;
          if (bcnt_q == BCW'(FRAME_W - 1)) begin
            // chain the waiting frame straight after the stop bit
            if (full_q) begin
              shift_q <= hold_q;
              full_q  <= 1'b0;
              bcnt_q  <= '0;
            end else begin
              busy_q <= 1'b0;
            end
          end else begin
            shift_q <= {1'b1, shift_q[FRAME_W-1:1]};
            bcnt_q  <= bcnt_q + 1'b1;
          end
        end else begin
          tcnt_q <= tcnt_q + 1'b1;
        end
      end
    end
  end

  assign tdre_o = !full_q;
  assign busy_o = busy_q;
  assign txd_o  = busy_q ? shift_q[0] : 1'b1;

  AST_TDRE_DROPS_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni) (load_i && tdre_o) |=> !tdre_o); // R2
  AST_LINE_HOLDS_BETWEEN_TICKS: assert property (@(posedge clk_i) disable iff (!rst_ni) (busy_o && !tick_i) |=> $stable(txd_o)); // R1
endmodule

// File: rtl/sci_rx.sv
module sci_rx import sci_pkg::*; #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              standby_set_i,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o,
  output logic              fe_o,
  output logic              standby_o
);
  localparam int unsigned FRAME_W    = DATA_W + 2;
  localparam int unsigned TCW        = $clog2(OVS);
  localparam int unsigned BCW        = $clog2(DATA_W);
  localparam int unsigned MID        = OVS / 2;
  localparam int unsigned IDLE_TICKS = FRAME_W * OVS;
  localparam int unsigned ICW        = $clog2(IDLE_TICKS + 1);
  localparam logic [TCW-1:0] D_LO     = TCW'(MID - 1);
  localparam logic [TCW-1:0] D_HI     = TCW'(MID + 1);
  localparam logic [TCW-1:0] S_LO     = TCW'(MID - 3);
  localparam logic [TCW-1:0] S_HI     = TCW'(MID + 3);
  localparam logic [TCW-1:0] LATE_HI  = TCW'(MID / 2 - 1);
  localparam logic [TCW-1:0] EARLY_LO = TCW'(OVS - MID / 2);
  localparam logic [TCW-1:0] PH_LAST  = TCW'(OVS - 1);

  rx_state_e         state_q;
  logic              s1_q, s2_q, prev_q;
  logic [TCW-1:0]    ph_q;
  logic [BCW-1:0]    bidx_q;
  logic [2:0]        ones_q;
  logic [DATA_W-1:0] shreg_q, data_q;
  logic              done_q, fe_q, standby_q;
  logic [ICW-1:0]    idle_q;

  logic           fall, wide, in_win, bit_val, late_edge, early_edge;
  logic [TCW-1:0] win_lo, win_hi;
  logic [2:0]     ones_nx;

  always_comb begin
    fall       = prev_q && !s2_q;
    wide       = (state_q == RX_START) || (state_q == RX_STOP);
    win_lo     = wide ? S_LO : D_LO;
    win_hi     = wide ? S_HI : D_HI;
    in_win     = (ph_q >= win_lo) && (ph_q <= win_hi);
    ones_nx    = ones_q + 3'(s2_q);
    bit_val    = wide ? (ones_nx >= 3'd4) : (ones_nx >= 3'd2);
    late_edge  = fall && (ph_q != '0) && (ph_q <= LATE_HI);
    early_edge = fall && (ph_q >= EARLY_LO);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= RX_IDLE;
      s1_q      <= 1'b1;
      s2_q      <= 1'b1;
      prev_q    <= 1'b1;
      ph_q      <= '0;
      bidx_q    <= '0;
      ones_q    <= '0;
      shreg_q   <= '0;
      data_q    <= '0;
      done_q    <= 1'b0;
      fe_q      <= 1'b0;
      standby_q <= 1'b0;
      idle_q    <= '0;
    end else begin
      s1_q   <= rxd_i;
      s2_q   <= s1_q;
      done_q <= 1'b0;
      if (tick_i) begin
        prev_q <= s2_q;
        if (!s2_q) idle_q <= '0;
        else if (idle_q != ICW'(IDLE_TICKS)) idle_q <= idle_q + 1'b1;
        if (standby_q && s2_q && idle_q == ICW'(IDLE_TICKS - 1)) standby_q <= 1'b0;

        if (state_q == RX_IDLE) begin
          if (fall) begin
            state_q <= RX_START;
            ph_q    <= TCW'(1);
            ones_q  <= '0;
          end
        end else if (late_edge) begin
          // edge arrived late: restart the current bit here
          ph_q   <= TCW'(1);
          ones_q <= '0;
        end else if (early_edge || ph_q == PH_LAST) begin
          // boundary reached (early edge or end of count): next bit
          ph_q   <= early_edge ? TCW'(1) : '0;
          ones_q <= '0;
          if (state_q == RX_START) begin
            state_q <= RX_DATA;
            bidx_q  <= '0;
          end else if (state_q == RX_DATA) begin
            if (bidx_q == BCW'(DATA_W - 1)) state_q <= RX_STOP;
            else bidx_q <= bidx_q + 1'b1;
          end
        end else begin
          ph_q <= ph_q + 1'b1;
          if (in_win) ones_q <= ones_nx;
          if (ph_q == win_hi) begin
            unique case (state_q)
              RX_START: if (bit_val) state_q <= RX_IDLE;
              RX_DATA:  shreg_q <= {bit_val, shreg_q[DATA_W-1:1]};
              RX_STOP: begin
                data_q  <= shreg_q;
                fe_q    <= !bit_val;
                done_q  <= !standby_q;
                state_q <= RX_IDLE;
              end
              default: ;
            endcase
          end
        end
      end
      if (standby_set_i) begin
        standby_q <= 1'b1;
        idle_q    <= '0;
      end
    end
  end

  assign data_o    = data_q;
  assign done_o    = done_q;
  assign fe_o      = fe_q;
  assign standby_o = standby_q;

  AST_STANDBY_NEEDS_HIGH_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni) (standby_o && !s2_q) |=> standby_o); // R10
  AST_DONE_IS_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |=> !done_o); // R4
endmodule

// File: rtl/sci_uart.sv
module sci_uart import sci_pkg::*; #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              txd_o,
  input  logic              rxd_i
);
  localparam int unsigned FRAME_W = DATA_W + 2;

  logic               tx_load, tdre, tx_busy, standby_set, rd_clr;
  logic [FRAME_W-1:0] tx_frame;
  logic [DATA_W-1:0]  rx_data, rbuf_q;
  logic               rx_done, rx_fe, standby;
  logic               rdrf_q, ovr_q, fe_q;

  always_comb begin
    tx_load  = 1'b0;
    tx_frame = {1'b1, wdata_i, 1'b0};
    if (wr_i) begin
      if (addr_i == REG_DATA) begin
        tx_load = 1'b1;
      end else if (addr_i == REG_CTRL) begin
        if (wdata_i[2]) begin
          tx_load  = 1'b1;
          tx_frame = '0;
        end else if (wdata_i[1]) begin
          tx_load  = 1'b1;
          tx_frame = '1;
        end
      end
    end
  end

  assign standby_set = wr_i && (addr_i == REG_CTRL) && wdata_i[0];
  assign rd_clr      = rd_i && (addr_i == REG_DATA);

  sci_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk_i, .rst_ni, .tick_i,
    .load_i (tx_load),
    .frame_i(tx_frame),
    .tdre_o (tdre),
    .busy_o (tx_busy),
    .txd_o
  );

  sci_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk_i, .rst_ni, .tick_i, .rxd_i,
    .standby_set_i(standby_set),
    .data_o       (rx_data),
    .done_o       (rx_done),
    .fe_o         (rx_fe),
    .standby_o    (standby)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbuf_q <= '0;
      rdrf_q <= 1'b0;
      ovr_q  <= 1'b0;
      fe_q   <= 1'b0;
    end else begin
      if (rd_clr) begin
        rdrf_q <= 1'b0;
        ovr_q  <= 1'b0;
        fe_q   <= 1'b0;
      end
      if (rx_done) begin
        if (rdrf_q && !rd_clr) begin
          ovr_q <= 1'b1;
        end else begin
          rbuf_q <= rx_data;
          rdrf_q <= 1'b1;
          fe_q   <= rx_fe;
        end
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      REG_DATA: rdata_o = rbuf_q;
      REG_STAT: rdata_o = {{(DATA_W-6){1'b0}}, tx_busy, standby, fe_q, ovr_q, rdrf_q, tdre};
      default:  rdata_o = '0;
    endcase
  end

  AST_OVR_ONLY_WITH_RDRF: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(ovr_q) |-> rdrf_q); // R9
  AST_READ_EMPTIES_BUFFER: assert property (@(posedge clk_i) disable iff (!rst_ni) (rd_clr && !rx_done) |=> !rdrf_q); // R4
endmodule

// File: tb/sim_sci_uart.sv
`timescale 1ns/1ps
module sim_sci_uart;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       txd;
  logic       rxd = 1'b1;

  int vectors = 0, errors = 0, tdiv = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sci_uart u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .txd_o(txd), .rxd_i(rxd)
  );

  always @(posedge clk) begin
    if (!rst_n) begin tdiv <= 0; tick <= 1'b0; end
    else begin tdiv <= (tdiv == 3) ? 0 : tdiv + 1; tick <= (tdiv == 3); end
  end

  // behavioural transmit reference
  logic [9:0] m_hold, m_lf;
  bit m_full, m_busy, m_ld;
  bit m_bits[$];
  int m_cnt;

  task automatic m_start();
    for (int i = 0; i < 10; i++) m_bits.push_back(m_hold[i]);
    m_busy = 1'b1; m_cnt = 0; m_full = 1'b0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_full = 0; m_busy = 0; m_cnt = 0; m_bits.delete();
    end else begin
      m_ld = 0; m_lf = '0;
      if (wr && !m_full) begin
        if (addr == 2'd0) begin m_ld = 1; m_lf = {1'b1, wdata, 1'b0}; end
        else if (addr == 2'd1 && wdata[2]) begin m_ld = 1; m_lf = 10'h000; end
        else if (addr == 2'd1 && wdata[1]) begin m_ld = 1; m_lf = 10'h3FF; end
      end
      if (tick) begin
        if (!m_busy) begin
          if (m_full) m_start();
        end else begin
          m_cnt++;
          if (m_cnt == 16) begin
            m_cnt = 0;
            void'(m_bits.pop_front());
            if (m_bits.size() == 0) begin
              if (m_full) m_start(); else m_busy = 0;
            end
          end
        end
      end
      if (m_ld) begin m_hold = m_lf; m_full = 1; end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic exp_txd;
      exp_txd = m_busy ? m_bits[0] : 1'b1;
      vectors++;
      if (txd !== exp_txd) begin
        errors++;
        $display("FAIL R1 txd at %0t: actual %b expected %b", $time, txd, exp_txd);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0; addr = 2'd2;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0; addr = 2'd2;
  endtask

  task automatic tx_drain();
    while (m_busy || m_full) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // drive one frame; optional one-tick inversion of bit gbit starting at clock gat
  task automatic rx_frame(input logic [9:0] f, input int cpb, input int gbit, input int gat);
    for (int i = 0; i < 10; i++)
      for (int c = 0; c < cpb; c++) begin
        @(negedge clk);
        rxd = f[i] ^ (i == gbit && c >= gat && c < gat + 4);
      end
    @(negedge clk); rxd = 1'b1;
  endtask

  function automatic logic [9:0] fr(input logic [7:0] d);
    return {1'b1, d, 1'b0};
  endfunction

  task automatic summary();
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R11 reset state
    check("R11 txd", txd, 1);
    rd_reg(2'd2, d); check("R11 status", d, 8'h01);
    rd_reg(2'd0, d); check("R11 rbuf", d, 8'h00);

    // R1 single frame, line compared every clock
    wr_reg(2'd0, 8'hA5);
    tx_drain();
    rd_reg(2'd2, d); check("R2 tdre after drain", d[0], 1);

    // R2 queueing and ignored write
    wr_reg(2'd0, 8'h11);
    repeat (6) @(negedge clk);
    wr_reg(2'd0, 8'h22);
    wr_reg(2'd0, 8'h33);
    rd_reg(2'd2, d); check("R2 tdre while full", d[0], 0);
    tx_drain();

    // R3 idle, break, and break priority
    wr_reg(2'd1, 8'h02);
    repeat (20) @(negedge clk);
    rd_reg(2'd2, d); check("R3 busy during idle char", d[5], 1);
    check("R3 line high in idle char", txd, 1);
    tx_drain();
    wr_reg(2'd1, 8'h06);
    repeat (100) @(negedge clk);
    check("R3 break wins", txd, 0);
    tx_drain();
    wr_reg(2'd1, 8'h04);
    tx_drain();

    // R4 plain receive
    rx_frame(fr(8'hA5), 64, -1, 0); repeat (40) @(negedge clk);
    rd_reg(2'd2, d); check("R4 rdrf set", d[1], 1);
    rd_reg(2'd0, d); check("R4 data", d, 8'hA5);
    rd_reg(2'd2, d); check("R4 rdrf cleared", d[1], 0);

    // R6 glitch in start bit
    rx_frame(fr(8'h3C), 64, 0, 28); repeat (40) @(negedge clk);
    rd_reg(2'd2, d); check("R6 start glitch rdrf", d[3:1], 3'b001);
    rd_reg(2'd0, d); check("R6 start glitch data", d, 8'h3C);
    // R6 glitch in stop bit
    rx_frame(fr(8'hC3), 64, 9, 28); repeat (40) @(negedge clk);
    rd_reg(2'd2, d); check("R6 stop glitch no fe", d[3:1], 3'b001);
    rd_reg(2'd0, d); check("R6 stop glitch data", d, 8'hC3);
    // R5 glitch in a data bit
    rx_frame(fr(8'h3C), 64, 2, 32); repeat (40) @(negedge clk);
    rd_reg(2'd0, d); check("R5 data majority", d, 8'h3C);
    rx_frame(fr(8'h3C), 64, 4, 32); repeat (40) @(negedge clk);
    rd_reg(2'd0, d); check("R5 data majority one-bit", d, 8'h3C);

    // R7 fast and slow senders
    rx_frame(fr(8'h55), 60, -1, 0); repeat (40) @(negedge clk);
    rd_reg(2'd2, d); check("R7 fast flags", d[3:1], 3'b001);
    rd_reg(2'd0, d); check("R7 fast data", d, 8'h55);
    rx_frame(fr(8'h55), 68, -1, 0); repeat (40) @(negedge clk);
    rd_reg(2'd2, d); check("R7 slow flags", d[3:1], 3'b001);
    rd_reg(2'd0, d); check("R7 slow data", d, 8'h55);

    // R8 framing error
    rx_frame({1'b0, 8'h5A, 1'b0}, 64, -1, 0); repeat (40) @(negedge clk);
    rd_reg(2'd2, d); check("R8 fe and rdrf", d[3:1], 3'b101);
    rd_reg(2'd0, d); check("R8 data", d, 8'h5A);
    rd_reg(2'd2, d); check("R8 fe cleared", d[3:1], 3'b000);

    // R9 overrun
    rx_frame(fr(8'h12), 64, -1, 0); repeat (20) @(negedge clk);
    rx_frame(fr(8'h34), 64, -1, 0); repeat (40) @(negedge clk);
    rd_reg(2'd2, d); check("R9 overrun", d[2:1], 2'b11);
    rd_reg(2'd0, d); check("R9 keeps first", d, 8'h12);
    rd_reg(2'd2, d); check("R9 cleared", d[2:1], 2'b00);

    // R10 wakeup standby
    wr_reg(2'd1, 8'h01);
    rd_reg(2'd2, d); check("R10 standby entered", d[4], 1);
    rx_frame(fr(8'h77), 64, -1, 0);
    rx_frame(fr(8'h88), 64, -1, 0);
    repeat (40) @(negedge clk);
    rd_reg(2'd2, d); check("R10 ignored in standby", d[4:1], 4'b1000);
    repeat (700) @(negedge clk);
    rd_reg(2'd2, d); check("R10 standby left", d[4], 0);
    rx_frame(fr(8'h99), 64, -1, 0); repeat (40) @(negedge clk);
    rd_reg(2'd2, d); check("R10 next char rdrf", d[1], 1);
    rd_reg(2'd0, d); check("R10 next char data", d, 8'h99);

    repeat (10) @(negedge clk);
    summary();
  end
endmodule